// File: doc/BRIEF.md
# Wavetable Sound Channel Bank

This block holds six independent wavetable tone channels behind a single byte-wide write port. Software first writes a channel number into a select register. Later writes to the per-channel offsets then land in that channel's pitch divider, control byte, stereo balance or wave-sample port. Each channel keeps its own 32-entry memory of 5-bit samples. Samples are loaded one after another through a data port whose write pointer wraps around, and a bit in the control byte moves that pointer back to entry zero.

When a channel is enabled, a down-counter reloads from its 12-bit divider. Each time the counter expires, the channel moves to the next stored sample. The channel then presents the current sample, scaled by its own volume, the shared main level and its balance, as separate left and right products. Each channel's products sit side by side on two wide output buses, which feed a mixer and a DAC downstream.

Top module: `wave_bank`

## Requirements
- R1: After reset, every register, pointer, counter and wave entry is zero, the select register is 0, and both output buses read zero.
- R2: Offset 0 stores wr_data[2:0] as the channel select. Writes to offsets 2 to 6 go only to the selected channel, and they change nothing when the select value is 6 or 7.
- R3: Offset 1 sets the main level: wr_data[7:4] is the left level and wr_data[3:0] is the right level, shared by all channels.
- R4: Offset 2 sets divider bits [7:0] from wr_data[7:0]. Offset 3 sets divider bits [11:8] from wr_data[3:0], and wr_data[7:4] is ignored.
- R5: Offset 4 is the control byte: bit 7 enables playback, bits [4:0] are the channel volume, and bit 6 set returns the wave write pointer to entry 0.
- R6: Offset 5 sets the channel balance: wr_data[7:4] is the left balance and wr_data[3:0] is the right balance.
- R7: A write to offset 6 on a disabled channel stores wr_data[4:0] at the write pointer, then advances the pointer modulo 32.
- R8: A write to offset 6 on an enabled channel changes neither the wave memory nor the write pointer.
- R9: While a channel is disabled, its read pointer is 0 and its counter holds the divider value. While it is enabled, the counter decrements every cycle; when it is at 0 it reloads and the read pointer advances modulo 32. A sample therefore lasts divider+1 cycles.
- R10: Channel c drives bits [c*18 +: 18] of each output bus. The left product is sample × volume × main left × balance left, the right product uses the right levels, and both are zero while the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset |
| wr_data | input | 8 | Register write data |
| out_left | output | 108 | Left products, 18 bits per channel |
| out_right | output | 108 | Right products, 18 bits per channel |

## Verification
The assertions check every cycle that:
- at most one channel is the target of a write;
- the select and main-level registers hold between writes;
- the read pointer stands still while the counter is non-zero and steps by one when it expires;
- the write pointer clears, advances or freezes as R5, R7 and R8 require.

The arithmetic of the scaled products, the routing through the select register and the exact sample timing after an enable can only be shown by the bench's scenarios. The bench compares both output buses every cycle against its own model of the channel state.

// File: rtl/wb_pkg.sv
package wb_pkg;

    // Register offsets on the byte-wide write port.
    typedef enum logic [2:0] {
        REG_SEL   = 3'd0,
        REG_MAIN  = 3'd1,
        REG_FLO   = 3'd2,
        REG_FHI   = 3'd3,
        REG_CTRL  = 3'd4,
        REG_BAL   = 3'd5,
        REG_WAVE  = 3'd6,
        REG_SPARE = 3'd7
    } wb_reg_e;

    localparam int DATA_W        = 8;
    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_WRST_BIT = 6;

endpackage

// File: rtl/wb_regs.sv
module wb_regs
    import wb_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int SEL_W = 3,
    parameter int LVL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [LVL_W-1:0]  main_l_o,
    output logic [LVL_W-1:0]  main_r_o,
    output logic [NCH-1:0]    ch_we_o
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [LVL_W-1:0] ml;
        logic [LVL_W-1:0] mr;
    } glob_t;

    glob_t glob_d, glob_q;
    logic  chan_reg;

    always_comb begin
        glob_d = glob_q;
        if (wr_en) begin
            case (wb_reg_e'(wr_addr))
                REG_SEL: glob_d.sel = wr_data[SEL_W-1:0];
                REG_MAIN: begin
                    glob_d.ml = wr_data[DATA_W-1 -: LVL_W];
                    glob_d.mr = wr_data[LVL_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        chan_reg = (wr_addr >= 3'(REG_FLO)) && (wr_addr <= 3'(REG_WAVE));
        ch_we_o  = '0;
        for (int c = 0; c < NCH; c++) begin
            ch_we_o[c] = wr_en && chan_reg && (glob_q.sel == SEL_W'(c));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) glob_q <= '0;
        else        glob_q <= glob_d;
    end

    assign main_l_o = glob_q.ml;
    assign main_r_o = glob_q.mr;

    // R2: a write reaches at most one channel
    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_we_o));

    // R2: select holds unless offset 0 is written
    a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 3'(REG_SEL)) |=> $stable(glob_q.sel));

    // R3: main levels hold unless offset 1 is written
    a_r3_main_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 3'(REG_MAIN)) |=> ($stable(main_l_o) && $stable(main_r_o)));

endmodule

// File: rtl/wb_channel.sv
module wb_channel
    import wb_pkg::*;
#(
    parameter int SAMP_W = 5,
    parameter int DEPTH  = 32,
    parameter int PTR_W  = 5,
    parameter int FREQ_W = 12,
    parameter int VOL_W  = 5,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [2:0]        addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              en_o,
    output logic [VOL_W-1:0]  vol_o,
    output logic [LVL_W-1:0]  bal_l_o,
    output logic [LVL_W-1:0]  bal_r_o,
    output logic [SAMP_W-1:0] sample_o
);

    typedef struct packed {
        logic [DEPTH-1:0][SAMP_W-1:0] mem;
        logic [FREQ_W-1:0]            freq;
        logic [FREQ_W-1:0]            cnt;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic                         en;
        logic [VOL_W-1:0]             vol;
        logic [LVL_W-1:0]             bl;
        logic [LVL_W-1:0]             br;
    } chan_t;

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;

        // playback sequencing uses the registered enable
        if (ch_q.en) begin
            if (ch_q.cnt == '0) begin
                ch_d.cnt = ch_q.freq;
                ch_d.rd  = ch_q.rd + 1'b1;
            end else begin
                ch_d.cnt = ch_q.cnt - 1'b1;
            end
        end else begin
            ch_d.cnt = ch_q.freq;
            ch_d.rd  = '0;
        end

        if (we_i) begin
            case (wb_reg_e'(addr_i))
                REG_FLO: ch_d.freq[7:0] = data_i;
                REG_FHI: ch_d.freq[FREQ_W-1:8] = data_i[FREQ_W-9:0];
                REG_CTRL: begin
                    ch_d.en  = data_i[CTRL_EN_BIT];
                    ch_d.vol = data_i[VOL_W-1:0];
                    if (data_i[CTRL_WRST_BIT]) ch_d.wr = '0;
                end
                REG_BAL: begin
                    ch_d.bl = data_i[DATA_W-1 -: LVL_W];
                    ch_d.br = data_i[LVL_W-1:0];
                end
                REG_WAVE: begin
                    if (!ch_q.en) begin
                        ch_d.mem[ch_q.wr] = data_i[SAMP_W-1:0];
                        ch_d.wr           = ch_q.wr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign en_o     = ch_q.en;
    assign vol_o    = ch_q.vol;
    assign bal_l_o  = ch_q.bl;
    assign bal_r_o  = ch_q.br;
    assign sample_o = ch_q.mem[ch_q.rd];

    // R9: sample position holds while the counter is running
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.en && ch_q.cnt != '0) |=> $stable(ch_q.rd));

    // R9: expiry advances the read pointer by one, wrapping
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.en && ch_q.cnt == '0) |=> (ch_q.rd == PTR_W'($past(ch_q.rd) + 1'b1)));

    // R5: control byte with bit 6 clears the write pointer
    a_r5_wclear: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == 3'(REG_CTRL) && data_i[CTRL_WRST_BIT]) |=> (ch_q.wr == '0));

    // R7: accepted sample advances the write pointer
    a_r7_wstep: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == 3'(REG_WAVE) && !ch_q.en) |=> (ch_q.wr == PTR_W'($past(ch_q.wr) + 1'b1)));

    // R8: data port is locked while playing
    a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == 3'(REG_WAVE) && ch_q.en) |=> ($stable(ch_q.wr) && $stable(ch_q.mem)));

endmodule

// File: rtl/wb_scale.sv
module wb_scale #(
    parameter int SAMP_W = 5,
    parameter int VOL_W  = 5,
    parameter int LVL_W  = 4,
    parameter int PROD_W = 18
) (
    input  logic              en_i,
    input  logic [SAMP_W-1:0] sample_i,
    input  logic [VOL_W-1:0]  vol_i,
    input  logic [LVL_W-1:0]  main_i,
    input  logic [LVL_W-1:0]  bal_i,
    output logic [PROD_W-1:0] prod_o
);

    logic [PROD_W-1:0] full;

    always_comb begin
        full   = PROD_W'(sample_i) * PROD_W'(vol_i) * PROD_W'(main_i) * PROD_W'(bal_i);
        prod_o = en_i ? full : '0;
    end

endmodule

// File: rtl/wave_bank.sv
module wave_bank
    import wb_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int SAMP_W = 5,
    parameter int DEPTH  = 32,
    parameter int FREQ_W = 12,
    parameter int VOL_W  = 5,
    parameter int LVL_W  = 4,
    localparam int PROD_W = SAMP_W + VOL_W + 2 * LVL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            wr_addr,
    input  logic [7:0]            wr_data,
    output logic [NCH*PROD_W-1:0] out_left,
    output logic [NCH*PROD_W-1:0] out_right
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int SEL_W = $clog2(NCH);

    logic [LVL_W-1:0]  main_l, main_r;
    logic [NCH-1:0]    ch_we;
    logic [NCH-1:0]    ch_en;
    logic [VOL_W-1:0]  ch_vol    [NCH];
    logic [LVL_W-1:0]  ch_bl     [NCH];
    logic [LVL_W-1:0]  ch_br     [NCH];
    logic [SAMP_W-1:0] ch_sample [NCH];

    wb_regs #(.NCH(NCH), .SEL_W(SEL_W), .LVL_W(LVL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .main_l_o (main_l),
        .main_r_o (main_r),
        .ch_we_o  (ch_we)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        wb_channel #(
            .SAMP_W(SAMP_W), .DEPTH(DEPTH), .PTR_W(PTR_W),
            .FREQ_W(FREQ_W), .VOL_W(VOL_W), .LVL_W(LVL_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_i     (ch_we[c]),
            .addr_i   (wr_addr),
            .data_i   (wr_data),
            .en_o     (ch_en[c]),
            .vol_o    (ch_vol[c]),
            .bal_l_o  (ch_bl[c]),
            .bal_r_o  (ch_br[c]),
            .sample_o (ch_sample[c])
        );

        wb_scale #(.SAMP_W(SAMP_W), .VOL_W(VOL_W), .LVL_W(LVL_W), .PROD_W(PROD_W)) u_left (
            .en_i     (ch_en[c]),
            .sample_i (ch_sample[c]),
            .vol_i    (ch_vol[c]),
            .main_i   (main_l),
            .bal_i    (ch_bl[c]),
            .prod_o   (out_left[c*PROD_W +: PROD_W])
        );

        wb_scale #(.SAMP_W(SAMP_W), .VOL_W(VOL_W), .LVL_W(LVL_W), .PROD_W(PROD_W)) u_right (
            .en_i     (ch_en[c]),
            .sample_i (ch_sample[c]),
            .vol_i    (ch_vol[c]),
            .main_i   (main_r),
            .bal_i    (ch_br[c]),
            .prod_o   (out_right[c*PROD_W +: PROD_W])
        );

        // R10: a channel that is off contributes nothing on either side
        a_r10_silent: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[c] |-> (out_left[c*PROD_W +: PROD_W] == '0 && out_right[c*PROD_W +: PROD_W] == '0));
    end

endmodule

// File: tb/tb_wave_bank.sv
module tb_wave_bank;

    localparam int NCH = 6;
    localparam int PW  = 18;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_addr = '0;
    logic [7:0]      wr_data = '0;
    logic [NCH*PW-1:0] out_left, out_right;

    wave_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_left(out_left), .out_right(out_right)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit checking = 1'b0;
    string tag = "R1";

    // requirement-level model of the channel state
    int m_sel, m_ml, m_mr;
    int m_freq[NCH], m_cnt[NCH], m_rd[NCH], m_wp[NCH], m_vol[NCH], m_bl[NCH], m_br[NCH];
    bit m_en[NCH];
    int m_mem[NCH][32];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_ml = 0; m_mr = 0;
            for (int c = 0; c < NCH; c++) begin
                m_freq[c] = 0; m_cnt[c] = 0; m_rd[c] = 0; m_wp[c] = 0;
                m_vol[c] = 0; m_bl[c] = 0; m_br[c] = 0; m_en[c] = 1'b0;
                for (int k = 0; k < 32; k++) m_mem[c][k] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (m_en[c]) begin
                    if (m_cnt[c] == 0) begin
                        m_cnt[c] = m_freq[c];
                        m_rd[c]  = (m_rd[c] + 1) % 32;
                    end else m_cnt[c] = m_cnt[c] - 1;
                end else begin
                    m_cnt[c] = m_freq[c];
                    m_rd[c]  = 0;
                end
            end
            if (wr_en) begin
                int a, d, s;
                a = int'(wr_addr); d = int'(wr_data); s = m_sel;
                if (a == 0) m_sel = d % 8;
                else if (a == 1) begin m_ml = d / 16; m_mr = d % 16; end
                else if (a >= 2 && a <= 6 && s < NCH) begin
                    case (a)
                        2: m_freq[s] = (m_freq[s] / 256) * 256 + d;
                        3: m_freq[s] = (d % 16) * 256 + (m_freq[s] % 256);
                        4: begin
                            m_en[s]  = d[7];
                            m_vol[s] = d % 32;
                            if (d[6]) m_wp[s] = 0;
                        end
                        5: begin m_bl[s] = d / 16; m_br[s] = d % 16; end
                        default: if (!m_en[s]) begin
                            m_mem[s][m_wp[s]] = d % 32;
                            m_wp[s] = (m_wp[s] + 1) % 32;
                        end
                    endcase
                end
            end
        end
    end

    function automatic logic [NCH*PW-1:0] exp_bus(input bit left);
        logic [NCH*PW-1:0] v;
        v = '0;
        for (int c = 0; c < NCH; c++) begin
            int p;
            p = m_en[c] ? m_mem[c][m_rd[c]] * m_vol[c] *
                (left ? m_ml * m_bl[c] : m_mr * m_br[c]) : 0;
            v[c*PW +: PW] = PW'(p);
        end
        return v;
    endfunction

    always @(negedge clk) begin
        if (rst_n && checking && !done) begin
            logic [NCH*PW-1:0] el, er;
            el = exp_bus(1'b1);
            er = exp_bus(1'b0);
            checks++;
            if (out_left !== el || out_right !== er) begin
                errors++;
                $display("FAIL %s t=%0t left act=%h exp=%h right act=%h exp=%h",
                         tag, $time, out_left, el, out_right, er);
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d7a));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs zero right after reset
        checking = 1'b1;
        tag = "R1";
        idle(5);

        // R3 R6 R10: load channel 2 and play at full rate
        tag = "R3 R6 R7 R10";
        wr(0, 2); wr(1, 8'h9A); wr(5, 8'hC3); wr(2, 0); wr(3, 0); wr(4, 8'h40);
        for (int i = 0; i < 32; i++) wr(6, (i * 7 + 3) % 32);
        wr(4, 8'h80 | 21);
        idle(40);

        // R9: divider sets sample duration
        tag = "R9";
        wr(2, 5); idle(80); wr(2, 2); idle(30);

        // R4: high divider nibble, upper data bits ignored
        tag = "R4";
        wr(0, 3); wr(5, 8'hFF); wr(4, 8'h40);
        for (int i = 0; i < 8; i++) wr(6, i + 20);
        wr(2, 8'h01); wr(3, 8'hF1); wr(4, 8'h9F);
        idle(600);

        // R8: data port locked while channel 2 plays
        tag = "R8";
        wr(0, 2);
        for (int i = 0; i < 10; i++) wr(6, 31);
        idle(70);

        // R5 R7: pointer wrap and pointer clear through control bit 6
        tag = "R5 R7";
        wr(4, 8'h15); wr(6, 5); wr(4, 8'h55); wr(6, 9); wr(6, 17);
        wr(2, 0); wr(4, 8'h9F);
        idle(40);

        // R2: selects 6 and 7 reach no channel
        tag = "R2";
        wr(0, 7); wr(4, 8'h00); wr(2, 8'h33); wr(5, 0); wr(6, 1);
        idle(20);
        wr(0, 6); wr(4, 8'h00); wr(3, 8'h0F); idle(20);

        // R10: random register traffic
        tag = "R10 random";
        for (int i = 0; i < 3000; i++) begin
            int a, d;
            if ($urandom % 3 == 0) begin
                a = int'($urandom % 7);
                d = int'($urandom % 256);
                if (a == 3) d = int'($urandom % 2);
                if (a == 0) d = int'($urandom % 8);
                wr(a, d);
            end else idle(1);
        end
        idle(5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule